// File: doc/BRIEF.md
# CCD Readout Pixel Classifier

This block sits directly behind the analog-to-digital converter on a single CCD output stream. It follows the line-valid level and the per-sample strobe, keeps a running position within the current line and a count of lines since the last frame start, and from these attaches a class tag and a colour tag to every accepted sample. Every line delivered by one output opens with a fixed run of masked and transitional elements. The block separates this run into three kinds: first the serial-register prescan elements, then the fully shielded dark references, then a short band of photosensitive isolation columns. Only after that band do the image pixels begin.

The number of image pixels per line depends on the readout geometry. When one output drains a whole register, a line carries the full width. When two outputs split the register, each output carries half of it. Samples that arrive after the expected image run are tagged as overscan. The first few lines of each frame come from dummy rows at the edge of the array and are tagged as dummy rather than image. Image pixels carry the colour of their site in a 2x2 Bayer tile. The tile is phased so that, with no phase adjustment, the first image pixel of a frame is blue. A two-bit phase select lets outputs that start on other tile positions share the same block.

Downstream logic (black-level estimation, correction, demosaicing) consumes the tagged stream. Marks for the first sample and the last expected image sample of each line delimit the data, and a sticky flag records any line that ended before its image run was complete.

Top module: `ccd_pixel_classifier`

## Requirements
- R1: After reset, out_vld, out_sol, out_eol and err_short are 0 and out_class is 0.
- R2: Within a line, counting accepted samples from 0, positions 0..PRESCAN-1 are tagged 3'd0 (prescan), the next DARK positions are tagged 3'd1 (dark reference), and the next INSUL positions are tagged 3'd2 (insulating).
- R3: After the prefix (PRESCAN+DARK+INSUL positions) the next N positions are tagged 3'd3 (image), where N is USEFUL_ONE when mode_two is 0 and USEFUL_TWO when mode_two is 1. All later positions are tagged 3'd5 (overscan).
- R4: out_sol is 1 only for position 0 of a line. out_eol is 1 only for position prefix+N-1, on every line including dummy lines.
- R5: out_color is 2'b00 red, 2'b01 green, 2'b10 blue for image samples, and 2'b11 for every other class.
- R6: Let c be the image index parity XOR phase_sel[0], and let r be the image-row parity XOR phase_sel[1]. Then r=0 gives blue for c=0 and green for c=1, and r=1 gives green for c=0 and red for c=1. Image-row parity starts at 0 for the first non-dummy line of a frame and flips at the end of each later non-dummy line.
- R7: The first DUMMY_LINES lines after frame_start tag their image positions 3'd4 (dummy) with colour 2'b11, and these lines do not advance the image-row parity. Their overscan positions stay 3'd5.
- R8: err_short becomes 1 when line_valid falls after fewer than prefix+N accepted samples. It stays 1 until reset, and full or overscanned lines leave it unchanged.
- R9: A sample is accepted only when line_valid and pix_stb are both 1. Each accepted sample appears exactly once on the outputs one clock later with out_vld=1 and its data unchanged. A strobe while line_valid is 0 produces no output.
- R10: A frame_start pulse, given while line_valid is 0, restarts the line count, so the dummy-line run and the image-row parity begin again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse before the first line of a frame |
| mode_two | input | 1 | 0: one output reads the whole register; 1: two outputs share it |
| phase_sel | input | 2 | Bit 0 flips column phase, bit 1 flips row phase of the Bayer tile |
| line_valid | input | 1 | High for the duration of a line |
| pix_stb | input | 1 | Sample strobe |
| pix_data | input | DW | Digitized sample |
| out_vld | output | 1 | Tagged sample valid |
| out_data | output | DW | Sample data, delayed one cycle |
| out_class | output | 3 | Class tag |
| out_color | output | 2 | Bayer colour tag |
| out_sol | output | 1 | First sample of a line |
| out_eol | output | 1 | Last expected image sample of a line |
| err_short | output | 1 | Sticky short-line flag |

## Verification
The bench shrinks the geometry to PRESCAN=2, DARK=3, INSUL=2, USEFUL_ONE=8, USEFUL_TWO=4 and DUMMY_LINES=2. With these values a full line is 15 samples, so a single run can cover several frames. Each frame includes both dummy lines, several image rows that swap row phase, an overscanned line, a gapped strobe pattern, both geometry modes with different phase selects, and a short line that sets the sticky flag. With full-size values, every class boundary and the row alternation would sit thousands of cycles apart; the reduced values bring all of them into one short simulation.

// File: rtl/ccd_cls_pkg.sv
// Shared class and colour encodings for the CCD pixel classifier.
package ccd_cls_pkg;

    typedef enum logic [2:0] {
        CLS_PRESCAN  = 3'd0,
        CLS_DARK     = 3'd1,
        CLS_INSUL    = 3'd2,
        CLS_IMAGE    = 3'd3,
        CLS_DUMMY    = 3'd4,
        CLS_OVERSCAN = 3'd5
    } pix_class_e;

    typedef enum logic [1:0] {
        COL_RED   = 2'd0,
        COL_GREEN = 2'd1,
        COL_BLUE  = 2'd2,
        COL_NONE  = 2'd3
    } bayer_col_e;

    // Site colour of the 2x2 tile: even row B G, odd row G R.
    function automatic bayer_col_e site_color(input logic row_odd, input logic col_odd);
        if (!row_odd) return col_odd ? COL_GREEN : COL_BLUE;
        else          return col_odd ? COL_RED   : COL_GREEN;
    endfunction

endpackage

// File: rtl/ccd_pos_counter.sv
// Position and line tracker.
// Counts accepted samples within a line (saturating) and lines since frame
// start (saturating at the dummy-line count), keeps the image-row parity and
// raises a sticky flag when a line closes before its image run completes.
// Assumes frame_start arrives while line_valid is low and mode_two is steady
// across a line.
module ccd_pos_counter #(
    parameter int PREFIX      = 36,
    parameter int USEFUL_ONE  = 2300,
    parameter int USEFUL_TWO  = 1150,
    parameter int DUMMY_LINES = 4,
    parameter int POS_W       = 13,
    parameter int LC_W        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             line_valid,
    input  logic             accept,
    input  logic             mode_two,
    output logic [POS_W-1:0] pos,
    output logic             in_dummy,
    output logic             row_par,
    output logic             err_short
);
    localparam logic [POS_W-1:0] POS_MAX  = {POS_W{1'b1}};
    localparam logic [POS_W-1:0] FULL_ONE = POS_W'(PREFIX + USEFUL_ONE);
    localparam logic [POS_W-1:0] FULL_TWO = POS_W'(PREFIX + USEFUL_TWO);
    localparam logic [LC_W-1:0]  DUM_CNT  = LC_W'(DUMMY_LINES);

    logic            lv_q;
    logic            lv_fall;
    logic [LC_W-1:0] line_cnt;

    assign lv_fall  = lv_q && !line_valid;
    assign in_dummy = (line_cnt < DUM_CNT);

    // Remember line_valid to find the end of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) lv_q <= 1'b0;
        else        lv_q <= line_valid;
    end

    // Sample position within the current line, cleared at line end.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start || lv_fall) pos <= '0;
        else if (accept && pos != POS_MAX)    pos <= pos + 1'b1;
    end

    // Line count and image-row parity since frame start.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) begin
            line_cnt <= '0;
            row_par  <= 1'b0;
        end else if (lv_fall) begin
            if (in_dummy) line_cnt <= line_cnt + 1'b1;
            else          row_par  <= !row_par;
        end
    end

    // Sticky flag for a line that ended before its image run was complete.
    always_ff @(posedge clk) begin
        if (!rst_n) err_short <= 1'b0;
        else if (lv_fall && pos < (mode_two ? FULL_TWO : FULL_ONE)) err_short <= 1'b1;
    end

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_short |=> err_short);

    // R10
    frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (in_dummy || DUMMY_LINES == 0) && !row_par && pos == '0);

    // R7
    dummy_row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lv_fall && in_dummy && !frame_start) |=> $stable(row_par));

endmodule

// File: rtl/ccd_class_decode.sv
// Combinational classifier.
// Maps the line position, dummy state, row parity, geometry mode and phase
// select onto a class tag, a Bayer colour and the line start/end marks.
// Assumes pos counts accepted samples from 0 within the line.
module ccd_class_decode
    import ccd_cls_pkg::*;
#(
    parameter int PRESCAN    = 12,
    parameter int DARK       = 16,
    parameter int INSUL      = 8,
    parameter int USEFUL_ONE = 2300,
    parameter int USEFUL_TWO = 1150,
    parameter int POS_W      = 13
) (
    input  logic [POS_W-1:0] pos,
    input  logic             in_dummy,
    input  logic             row_par,
    input  logic             mode_two,
    input  logic [1:0]       phase_sel,
    output pix_class_e       cls,
    output bayer_col_e       color,
    output logic             sol,
    output logic             eol
);
    localparam int               PREFIX     = PRESCAN + DARK + INSUL;
    localparam logic [POS_W-1:0] END_PRE    = POS_W'(PRESCAN);
    localparam logic [POS_W-1:0] END_DARK   = POS_W'(PRESCAN + DARK);
    localparam logic [POS_W-1:0] END_INSUL  = POS_W'(PREFIX);
    localparam logic [POS_W-1:0] END_ONE    = POS_W'(PREFIX + USEFUL_ONE);
    localparam logic [POS_W-1:0] END_TWO    = POS_W'(PREFIX + USEFUL_TWO);
    localparam logic             PREFIX_ODD = (PREFIX % 2) == 1;

    logic [POS_W-1:0] img_end;
    logic             col_odd;
    logic             row_odd;

    // Select the image-run limit for the geometry in use.
    assign img_end = mode_two ? END_TWO : END_ONE;
    assign col_odd = pos[0] ^ PREFIX_ODD ^ phase_sel[0];
    assign row_odd = row_par ^ phase_sel[1];

    // Class from the position band the sample falls in.
    always_comb begin
        if      (pos < END_PRE)   cls = CLS_PRESCAN;
        else if (pos < END_DARK)  cls = CLS_DARK;
        else if (pos < END_INSUL) cls = CLS_INSUL;
        else if (pos < img_end)   cls = in_dummy ? CLS_DUMMY : CLS_IMAGE;
        else                      cls = CLS_OVERSCAN;
    end

    // Colour only for image samples.
    always_comb begin
        color = (cls == CLS_IMAGE) ? site_color(row_odd, col_odd) : COL_NONE;
    end

    // Line delimiters.
    assign sol = (pos == '0);
    assign eol = (pos == img_end - 1'b1);

endmodule

// File: rtl/ccd_tag_reg.sv
// Output stage.
// Registers the sample and its tags for one cycle so that the outputs leave
// the block from flops. Assumes the tags are valid whenever in_vld is high.
module ccd_tag_reg
    import ccd_cls_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [DW-1:0] in_data,
    input  pix_class_e    in_cls,
    input  bayer_col_e    in_color,
    input  logic          in_sol,
    input  logic          in_eol,
    output logic          out_vld,
    output logic [DW-1:0] out_data,
    output logic [2:0]    out_class,
    output logic [1:0]    out_color,
    output logic          out_sol,
    output logic          out_eol
);
    // Valid and marks follow every cycle; payload loads on a sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld   <= 1'b0;
            out_data  <= '0;
            out_class <= 3'd0;
            out_color <= 2'd0;
            out_sol   <= 1'b0;
            out_eol   <= 1'b0;
        end else begin
            out_vld <= in_vld;
            out_sol <= in_vld && in_sol;
            out_eol <= in_vld && in_eol;
            if (in_vld) begin
                out_data  <= in_data;
                out_class <= in_cls;
                out_color <= in_color;
            end
        end
    end

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld && !out_sol && !out_eol);

    // R4
    sol_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_sol) |-> out_class == 3'(CLS_PRESCAN));

    // R4
    eol_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_eol) |-> (out_class == 3'(CLS_IMAGE) || out_class == 3'(CLS_DUMMY)));

    // R5
    color_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ((out_class == 3'(CLS_IMAGE)) == (out_color != 2'(COL_NONE))));

endmodule

// File: rtl/ccd_pixel_classifier.sv
// CCD readout pixel classifier, top level.
// Tags each accepted sample of one output stream with its class and Bayer
// colour, one cycle after acceptance. Assumes frame_start is pulsed while
// line_valid is low and that mode_two and phase_sel change only between lines.
module ccd_pixel_classifier
    import ccd_cls_pkg::*;
#(
    parameter int DW          = 12,
    parameter int PRESCAN     = 12,
    parameter int DARK        = 16,
    parameter int INSUL       = 8,
    parameter int USEFUL_ONE  = 2300,
    parameter int USEFUL_TWO  = 1150,
    parameter int DUMMY_LINES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          mode_two,
    input  logic [1:0]    phase_sel,
    input  logic          line_valid,
    input  logic          pix_stb,
    input  logic [DW-1:0] pix_data,
    output logic          out_vld,
    output logic [DW-1:0] out_data,
    output logic [2:0]    out_class,
    output logic [1:0]    out_color,
    output logic          out_sol,
    output logic          out_eol,
    output logic          err_short
);
    localparam int PREFIX  = PRESCAN + DARK + INSUL;
    localparam int MAX_USE = (USEFUL_ONE > USEFUL_TWO) ? USEFUL_ONE : USEFUL_TWO;
    localparam int POS_W   = $clog2(PREFIX + MAX_USE + 1) + 1;
    localparam int LC_W    = $clog2(DUMMY_LINES + 1) + 1;

    logic             accept;
    logic [POS_W-1:0] pos;
    logic             in_dummy;
    logic             row_par;
    pix_class_e       cls;
    bayer_col_e       color;
    logic             sol;
    logic             eol;

    assign accept = line_valid && pix_stb;

    ccd_pos_counter #(
        .PREFIX      (PREFIX),
        .USEFUL_ONE  (USEFUL_ONE),
        .USEFUL_TWO  (USEFUL_TWO),
        .DUMMY_LINES (DUMMY_LINES),
        .POS_W       (POS_W),
        .LC_W        (LC_W)
    ) u_pos (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .line_valid  (line_valid),
        .accept      (accept),
        .mode_two    (mode_two),
        .pos         (pos),
        .in_dummy    (in_dummy),
        .row_par     (row_par),
        .err_short   (err_short)
    );

    ccd_class_decode #(
        .PRESCAN    (PRESCAN),
        .DARK       (DARK),
        .INSUL      (INSUL),
        .USEFUL_ONE (USEFUL_ONE),
        .USEFUL_TWO (USEFUL_TWO),
        .POS_W      (POS_W)
    ) u_dec (
        .pos       (pos),
        .in_dummy  (in_dummy),
        .row_par   (row_par),
        .mode_two  (mode_two),
        .phase_sel (phase_sel),
        .cls       (cls),
        .color     (color),
        .sol       (sol),
        .eol       (eol)
    );

    ccd_tag_reg #(
        .DW (DW)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (accept),
        .in_data   (pix_data),
        .in_cls    (cls),
        .in_color  (color),
        .in_sol    (sol),
        .in_eol    (eol),
        .out_vld   (out_vld),
        .out_data  (out_data),
        .out_class (out_class),
        .out_color (out_color),
        .out_sol   (out_sol),
        .out_eol   (out_eol)
    );

endmodule

// File: tb/test_ccd_pixel_classifier.sv
// Scoreboard bench: the driver pushes expected tagged samples, the monitor
// pops and compares them as the design emits them.
module test_ccd_pixel_classifier;
    localparam int DW = 12, PRE = 2, DRK = 3, INS = 2, U1 = 8, U2 = 4, DUM = 2;
    localparam int PFX = PRE + DRK + INS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          mode_two = 1'b0;
    logic [1:0]    phase_sel = 2'b00;
    logic          line_valid = 1'b0;
    logic          pix_stb = 1'b0;
    logic [DW-1:0] pix_data = '0;
    logic          out_vld;
    logic [DW-1:0] out_data;
    logic [2:0]    out_class;
    logic [1:0]    out_color;
    logic          out_sol;
    logic          out_eol;
    logic          err_short;

    int n_chk = 0;
    int n_bad = 0;
    int line_idx = 0;
    logic row = 1'b0;
    logic [DW-1:0] dcnt = 12'h100;
    logic [DW+6:0] expq [$];

    always #4 clk = !clk;

    ccd_pixel_classifier #(
        .DW(DW), .PRESCAN(PRE), .DARK(DRK), .INSUL(INS),
        .USEFUL_ONE(U1), .USEFUL_TWO(U2), .DUMMY_LINES(DUM)
    ) i_ccd_pixel_classifier (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .mode_two(mode_two),
        .phase_sel(phase_sel), .line_valid(line_valid), .pix_stb(pix_stb),
        .pix_data(pix_data), .out_vld(out_vld), .out_data(out_data),
        .out_class(out_class), .out_color(out_color), .out_sol(out_sol),
        .out_eol(out_eol), .err_short(err_short)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Expected item {data, class, colour, sol, eol} from the requirements.
    function automatic logic [DW+6:0] model(input int p, input logic [DW-1:0] d);
        int nuse = mode_two ? U2 : U1;
        logic [2:0] c;
        logic [1:0] col = 2'b11;
        logic er, ec;
        if (p < PRE) c = 3'd0;                            // R2
        else if (p < PRE + DRK) c = 3'd1;
        else if (p < PFX) c = 3'd2;
        else if (p < PFX + nuse) c = (line_idx < DUM) ? 3'd4 : 3'd3;  // R3 R7
        else c = 3'd5;
        if (c == 3'd3) begin                              // R5 R6
            er = row ^ phase_sel[1];
            ec = 1'((p - PFX) % 2) ^ phase_sel[0];
            col = !er ? (ec ? 2'b01 : 2'b10) : (ec ? 2'b00 : 2'b01);
        end
        return {d, c, col, (p == 0), (p == PFX + nuse - 1)};  // R4
    endfunction

    task automatic new_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        line_idx = 0;
        row = 1'b0;
    endtask

    // Drive one line of n samples; gap inserts an idle strobe cycle between them.
    task automatic drive_line(input int n, input logic gap);
        @(negedge clk);
        line_valid = 1'b1;
        for (int p = 0; p < n; p++) begin
            expq.push_back(model(p, dcnt));
            pix_stb = 1'b1;
            pix_data = dcnt;
            dcnt = dcnt + 12'h7;
            @(negedge clk);
            if (gap) begin
                pix_stb = 1'b0;
                @(negedge clk);
            end
        end
        pix_stb = 1'b0;
        line_valid = 1'b0;
        @(negedge clk);
        if (line_idx >= DUM) row = !row;
        line_idx++;
        // R9: a strobe with line_valid low must yield nothing
        pix_stb = 1'b1;
        @(negedge clk);
        pix_stb = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: compare each emitted sample with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            if (expq.size() == 0) begin
                check(1'b0, "R9 unexpected output", int'(out_data), 0);
            end else begin
                logic [DW+6:0] e;
                logic [DW+6:0] a;
                e = expq.pop_front();
                a = {out_data, out_class, out_color, out_sol, out_eol};
                check(a == e, "R2/R3/R4/R5/R6/R7/R9 tagged sample", int'(a), int'(e));
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!out_vld && !out_sol && !out_eol && !err_short && out_class == 3'd0,
              "R1 reset outputs", int'({out_vld, out_sol, out_eol, err_short, out_class}), 0);
        rst_n = 1'b1;
        // Frame A: one-output geometry, default phase
        new_frame();
        for (int l = 0; l < 5; l++) drive_line(PFX + U1, l == 3);
        drive_line(PFX + U1 + 3, 1'b0);                   // R3 overscan
        check(err_short == 1'b0, "R8 full lines leave flag clear", int'(err_short), 0);
        // Frame B: two-output geometry, column phase flipped (R10 restart)
        mode_two = 1'b1;
        phase_sel = 2'b01;
        new_frame();
        for (int l = 0; l < 4; l++) drive_line(PFX + U2, 1'b0);
        // Frame C: one-output geometry, row phase flipped
        mode_two = 1'b0;
        phase_sel = 2'b10;
        new_frame();
        for (int l = 0; l < 4; l++) drive_line(PFX + U1, l == 2);
        check(err_short == 1'b0, "R8 flag still clear", int'(err_short), 0);
        // Short line sets the sticky flag
        drive_line(PFX + 3, 1'b0);
        check(err_short == 1'b1, "R8 short line sets flag", int'(err_short), 1);
        new_frame();
        phase_sel = 2'b11;
        for (int l = 0; l < 3; l++) drive_line(PFX + U1, 1'b0);
        check(err_short == 1'b1, "R8 flag sticky", int'(err_short), 1);
        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R9 every sample emitted", expq.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule